// File: doc/BRIEF.md
# Two-Level Rate-Classed Queue Scheduler

This block picks which leaf queue transmits next. Leaf queues sit in groups under parent nodes, and one combinational pass resolves both levels. Each leaf carries three settings: a committed (minimum) rate, a ceiling (maximum) rate and an excess weight. Up to two leaves may be named as priority queues, one at level 1 and one at level 2. Every leaf keeps three counters. The first is a signed committed-rate credit. The second is a signed ceiling credit. Both are refilled on a periodic tick and charged by the length of each acknowledged dequeue. The third is a deficit counter that shares excess bandwidth in deficit round-robin order.

The grant is a valid/ready stream toward the dequeue logic. `gnt_valid` with `gnt_idx` and `gnt_cls` is held unchanged for as long as `gnt_ready` stays low, so back-pressure from downstream can last any number of cycles. A handshake is a cycle in which both `gnt_valid` and `gnt_ready` are high. In that cycle `deq_len` gives the number of bytes to charge to the granted leaf. In the cycle after a handshake no grant is offered. In that gap the scheduler works out the next decision from the updated credits. Configuration, queue occupancy and head lengths are plain level inputs.

Top module: `hsched_top`

## Requirements
- R1: After reset `gnt_valid` is low. It stays low in every cycle in which no leaf is eligible.
- R2: While `gnt_valid` is high and `gnt_ready` is low, `gnt_valid`, `gnt_idx` and `gnt_cls` hold their values, whatever the other inputs do. After a handshake `gnt_valid` is low for one cycle. A fresh decision is then loaded.
- R3: A candidate's class is encoded on `gnt_cls` as 3 = priority 1, 2 = priority 2, 1 = below committed rate, 0 = excess. A higher class always wins over a lower one.
- R4: With `cfg_p1_en` high, leaf `cfg_p1_id` is class 3. Otherwise, with `cfg_p2_en` high, leaf `cfg_p2_id` is class 2. If both name the same leaf, class 3 applies.
- R5: A parent competes with the highest class among its candidate children, so an urgent leaf in any group wins in one pass. Within a group, equal classes go to the lowest leaf index.
- R6: Groups tied at the winning class are resolved by a rotating pointer. After each handshake the pointer moves to the group after the granted one. Reset sets the pointer to group 0.
- R7: A leaf is eligible only while it is non-empty and its ceiling credit is not negative. A refill that brings the credit back to zero or above restores it.
- R8: Each tick adds the configured rate to both credits of every leaf. A handshake subtracts `deq_len` from both credits of the granted leaf. Credits saturate at the burst limit BURST (255) and start from 0 after reset.
- R9: A leaf that is not a priority leaf is class 1 while its committed credit is greater than zero, and class 0 otherwise.
- R10: A class 0 leaf is a candidate only when its deficit is at least its head length. If eligible leaves exist but none is a candidate, one cycle adds each eligible class 0 leaf's weight to its deficit and grants nothing. A class 0 handshake subtracts `deq_len` from the deficit. An empty leaf's deficit is cleared.
- R11: A grant is only formed for a leaf that was non-empty in the cycle the decision was taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| refill_tick | input | 1 | Credit refill strobe |
| q_nonempty | input | NQ | Per-leaf data present flag |
| q_head_len | input | NQ*LW | Per-leaf head packet length |
| cfg_min_rate | input | NQ*RW | Per-leaf committed refill amount |
| cfg_max_rate | input | NQ*RW | Per-leaf ceiling refill amount |
| cfg_weight | input | NQ*WW | Per-leaf excess quantum |
| cfg_p1_en | input | 1 | Enable priority-1 leaf |
| cfg_p1_id | input | QW | Priority-1 leaf index |
| cfg_p2_en | input | 1 | Enable priority-2 leaf |
| cfg_p2_id | input | QW | Priority-2 leaf index |
| gnt_valid | output | 1 | Grant offered |
| gnt_ready | input | 1 | Grant accepted |
| gnt_idx | output | QW | Granted leaf |
| gnt_cls | output | 2 | Class the grant was won in |
| deq_len | input | LW | Bytes charged at handshake |

## Verification
A sweep over every occupancy mask with only excess traffic checks the idle case and the lowest-index tie-break. Sweeps over every priority-1 and priority-2 leaf, alone and together, check class order against position. Directed sequences test the remaining rules. A committed-rate leaf in the second group beating the pointer shows that urgency propagates up the tree. Two committed leaves in different groups alternating shows the pointer rotating. Weights 20:10 producing the pattern 0,0,1 shows deficit sharing. A leaf that goes silent after an overdraft and returns after one tick shows the ceiling at work. A committed credit that lasts exactly three 100-byte grants after five refills of 100 shows that saturation takes effect.

// File: rtl/hsched_pkg.sv
package hsched_pkg;
  typedef enum logic [1:0] {
    CLS_EXC = 2'd0,
    CLS_MIN = 2'd1,
    CLS_P2  = 2'd2,
    CLS_P1  = 2'd3
  } cls_e;
endpackage

// File: rtl/hsched_leaf.sv
module hsched_leaf
  import hsched_pkg::*;
#(
  parameter int LW    = 8,
  parameter int RW    = 8,
  parameter int WW    = 8,
  parameter int CW    = 12,
  parameter int DW    = 10,
  parameter int BURST = 255
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          nonempty,
  input  logic [LW-1:0] head_len,
  input  logic [RW-1:0] min_rate,
  input  logic [RW-1:0] max_rate,
  input  logic [WW-1:0] weight,
  input  logic          is_p1,
  input  logic          is_p2,
  input  logic          charge,
  input  logic          charge_exc,
  input  logic [LW-1:0] charge_len,
  input  logic          replen,
  output logic          eligible,
  output logic          cand,
  output cls_e          cls
);
  localparam int XW = CW + 2;
  localparam logic signed [XW-1:0] HI = XW'(BURST);
  localparam logic signed [XW-1:0] LO = $signed({{(XW-CW+1){1'b1}}, {(CW-1){1'b0}}});
  localparam logic [DW:0] DMAX = {1'b0, {DW{1'b1}}};

  logic signed [CW-1:0] min_c, max_c;
  logic [DW-1:0] def;
  logic [DW-1:0] len_d, head_d;
  logic [DW:0]   def_add;

  function automatic logic signed [CW-1:0] step(input logic signed [CW-1:0] cur,
                                                 input logic [RW-1:0] rate,
                                                 input logic t, input logic c,
                                                 input logic [LW-1:0] len);
    logic signed [XW-1:0] v;
    v = $signed({{(XW-CW){cur[CW-1]}}, cur});
    if (t) v = v + $signed({{(XW-RW){1'b0}}, rate});
    if (c) v = v - $signed({{(XW-LW){1'b0}}, len});
    if (v > HI)      step = HI[CW-1:0];
    else if (v < LO) step = LO[CW-1:0];
    else             step = v[CW-1:0];
  endfunction

  assign len_d   = {{(DW-LW){1'b0}}, charge_len};
  assign head_d  = {{(DW-LW){1'b0}}, head_len};
  assign def_add = {1'b0, def} + {{(DW+1-WW){1'b0}}, weight};

  always_comb begin
    if (is_p1)                    cls = CLS_P1;
    else if (is_p2)               cls = CLS_P2;
    else if (!min_c[CW-1] && min_c != '0) cls = CLS_MIN;
    else                          cls = CLS_EXC;
  end

  assign eligible = nonempty && !max_c[CW-1];
  assign cand     = eligible && ((cls != CLS_EXC) || (def >= head_d));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      min_c <= '0;
      max_c <= '0;
      def   <= '0;
    end else begin
      min_c <= step(min_c, min_rate, tick, charge, charge_len);
      max_c <= step(max_c, max_rate, tick, charge, charge_len);
      if (!nonempty)
        def <= '0;
      else if (charge && charge_exc)
        def <= (def >= len_d) ? def - len_d : '0;
      else if (replen && eligible && cls == CLS_EXC)
        def <= (def_add > DMAX) ? DMAX[DW-1:0] : def_add[DW-1:0];
    end
  end
endmodule

// File: rtl/hsched_pick.sv
module hsched_pick
  import hsched_pkg::*;
#(
  parameter int NP  = 2,
  parameter int LPP = 2,
  parameter int NQ  = NP * LPP,
  parameter int QW  = 2,
  parameter int PW  = 1
) (
  input  logic [NQ-1:0] cand,
  input  cls_e          cls [NQ],
  input  logic [PW-1:0] ptr,
  output logic          found,
  output logic [QW-1:0] idx,
  output cls_e          wcls
);
  logic [NP-1:0] pv;
  cls_e          pc [NP];
  logic [QW-1:0] pi [NP];

  // level 1: best child of each group, lowest index on ties
  always_comb begin
    for (int p = 0; p < NP; p++) begin
      pv[p] = 1'b0;
      pc[p] = CLS_EXC;
      pi[p] = '0;
      for (int l = LPP - 1; l >= 0; l--) begin
        int q;
        q = p * LPP + l;
        if (cand[q] && (!pv[p] || cls[q] >= pc[p])) begin
          pv[p] = 1'b1;
          pc[p] = cls[q];
          pi[p] = QW'(q);
        end
      end
    end
  end

  // level 2: groups carry their best class upward; rotate among equals
  always_comb begin
    logic done;
    found = 1'b0;
    wcls  = CLS_EXC;
    for (int p = 0; p < NP; p++) begin
      if (pv[p] && (!found || pc[p] > wcls)) begin
        found = 1'b1;
        wcls  = pc[p];
      end
    end
    done = 1'b0;
    idx  = '0;
    for (int k = 0; k < NP; k++) begin
      int j;
      j = int'(ptr) + k;
      if (j >= NP) j = j - NP;
      if (!done && pv[j] && pc[j] == wcls) begin
        done = 1'b1;
        idx  = pi[j];
      end
    end
  end
endmodule

// File: rtl/hsched_top.sv
module hsched_top
  import hsched_pkg::*;
#(
  parameter int NP    = 2,
  parameter int LPP   = 2,
  parameter int LW    = 8,
  parameter int RW    = 8,
  parameter int WW    = 8,
  parameter int CW    = 12,
  parameter int DW    = 10,
  parameter int BURST = 255,
  localparam int NQ   = NP * LPP,
  localparam int QW   = $clog2(NQ),
  localparam int PW   = (NP > 1) ? $clog2(NP) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             refill_tick,
  input  logic [NQ-1:0]    q_nonempty,
  input  logic [NQ*LW-1:0] q_head_len,
  input  logic [NQ*RW-1:0] cfg_min_rate,
  input  logic [NQ*RW-1:0] cfg_max_rate,
  input  logic [NQ*WW-1:0] cfg_weight,
  input  logic             cfg_p1_en,
  input  logic [QW-1:0]    cfg_p1_id,
  input  logic             cfg_p2_en,
  input  logic [QW-1:0]    cfg_p2_id,
  output logic             gnt_valid,
  input  logic             gnt_ready,
  output logic [QW-1:0]    gnt_idx,
  output logic [1:0]       gnt_cls,
  input  logic [LW-1:0]    deq_len
);
  logic [NQ-1:0] elig, cand;
  cls_e          lcls [NQ];
  logic          hs, found, replen;
  logic [QW-1:0] pick_idx;
  cls_e          pick_cls;
  logic [PW-1:0] rr_ptr, nxt_ptr;

  assign hs     = gnt_valid && gnt_ready;
  assign replen = !gnt_valid && !found && (|elig);

  for (genvar i = 0; i < NQ; i++) begin : g_leaf
    hsched_leaf #(.LW(LW), .RW(RW), .WW(WW), .CW(CW), .DW(DW), .BURST(BURST)) u_leaf (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (refill_tick),
      .nonempty   (q_nonempty[i]),
      .head_len   (q_head_len[i*LW +: LW]),
      .min_rate   (cfg_min_rate[i*RW +: RW]),
      .max_rate   (cfg_max_rate[i*RW +: RW]),
      .weight     (cfg_weight[i*WW +: WW]),
      .is_p1      (cfg_p1_en && cfg_p1_id == QW'(i)),
      .is_p2      (cfg_p2_en && cfg_p2_id == QW'(i)),
      .charge     (hs && gnt_idx == QW'(i)),
      .charge_exc (gnt_cls == CLS_EXC),
      .charge_len (deq_len),
      .replen     (replen),
      .eligible   (elig[i]),
      .cand       (cand[i]),
      .cls        (lcls[i])
    );
  end

  hsched_pick #(.NP(NP), .LPP(LPP), .NQ(NQ), .QW(QW), .PW(PW)) u_pick (
    .cand  (cand),
    .cls   (lcls),
    .ptr   (rr_ptr),
    .found (found),
    .idx   (pick_idx),
    .wcls  (pick_cls)
  );

  always_comb begin
    int pp;
    pp = int'(gnt_idx) / LPP;
    nxt_ptr = (pp >= NP - 1) ? '0 : PW'(pp + 1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gnt_valid <= 1'b0;
      gnt_idx   <= '0;
      gnt_cls   <= CLS_EXC;
      rr_ptr    <= '0;
    end else if (hs) begin
      gnt_valid <= 1'b0;
      rr_ptr    <= nxt_ptr;
    end else if (!gnt_valid && found) begin
      gnt_valid <= 1'b1;
      gnt_idx   <= pick_idx;
      gnt_cls   <= pick_cls;
    end
  end
endmodule

// File: rtl/hsched_chk.sv
module hsched_chk
  import hsched_pkg::*;
#(
  parameter int NQ = 4,
  parameter int QW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NQ-1:0] q_nonempty,
  input logic          cfg_p1_en,
  input logic [QW-1:0] cfg_p1_id,
  input logic          gnt_valid,
  input logic          gnt_ready,
  input logic [QW-1:0] gnt_idx,
  input logic [1:0]    gnt_cls
);
  // R2
  grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid && !gnt_ready |=> gnt_valid && $stable(gnt_idx) && $stable(gnt_cls));

  // R2
  gap_after_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid && gnt_ready |=> !gnt_valid);

  // R11
  grant_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gnt_valid) |-> ((($past(q_nonempty) >> gnt_idx) & NQ'(1)) != '0));

  // R4
  p1_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gnt_valid) && gnt_cls == CLS_P1 |-> $past(cfg_p1_en) && gnt_idx == $past(cfg_p1_id));
endmodule

bind hsched_top hsched_chk #(.NQ(NQ), .QW(QW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .q_nonempty (q_nonempty),
  .cfg_p1_en  (cfg_p1_en),
  .cfg_p1_id  (cfg_p1_id),
  .gnt_valid  (gnt_valid),
  .gnt_ready  (gnt_ready),
  .gnt_idx    (gnt_idx),
  .gnt_cls    (gnt_cls)
);

// File: tb/tb_hsched_top.sv
`timescale 1ns/1ps
module tb_hsched_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        refill_tick;
  logic [3:0]  q_nonempty;
  logic [31:0] q_head_len, cfg_min_rate, cfg_max_rate, cfg_weight;
  logic        cfg_p1_en, cfg_p2_en;
  logic [1:0]  cfg_p1_id, cfg_p2_id;
  logic        gnt_valid, gnt_ready;
  logic [1:0]  gnt_idx, gnt_cls;
  logic [7:0]  deq_len;
  int nchk = 0;
  int nfail = 0;

  always #2.5 clk = ~clk;

  hsched_top dut (
    .clk(clk), .rst_n(rst_n), .refill_tick(refill_tick), .q_nonempty(q_nonempty),
    .q_head_len(q_head_len), .cfg_min_rate(cfg_min_rate), .cfg_max_rate(cfg_max_rate),
    .cfg_weight(cfg_weight), .cfg_p1_en(cfg_p1_en), .cfg_p1_id(cfg_p1_id),
    .cfg_p2_en(cfg_p2_en), .cfg_p2_id(cfg_p2_id), .gnt_valid(gnt_valid),
    .gnt_ready(gnt_ready), .gnt_idx(gnt_idx), .gnt_cls(gnt_cls), .deq_len(deq_len)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; refill_tick = 1'b0; q_nonempty = '0;
    q_head_len = {4{8'd10}}; cfg_min_rate = '0; cfg_max_rate = '0;
    cfg_weight = {4{8'd16}}; cfg_p1_en = 1'b0; cfg_p2_en = 1'b0;
    cfg_p1_id = '0; cfg_p2_id = '0; gnt_ready = 1'b0; deq_len = 8'd10;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic tick();
    refill_tick = 1'b1; @(negedge clk); refill_tick = 1'b0;
  endtask

  task automatic ack(input int len);
    deq_len = 8'(len); gnt_ready = 1'b1; @(negedge clk); gnt_ready = 1'b0;
  endtask

  task automatic wait_grant();
    for (int i = 0; i < 20; i++) begin
      if (gnt_valid) break;
      @(negedge clk);
    end
  endtask

  task automatic expect_grant(input string tag, input int idx, input int cls);
    wait_grant();
    check(gnt_valid, {tag, " valid"}, int'(gnt_valid), 1);
    check(gnt_idx == 2'(idx), {tag, " idx"}, int'(gnt_idx), idx);
    check(gnt_cls == 2'(cls), {tag, " cls"}, int'(gnt_cls), cls);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
    $finish;
  end

  initial begin
    // R1: reset state and idle
    do_reset();
    check(!gnt_valid, "R1 reset", int'(gnt_valid), 0);
    repeat (5) @(negedge clk);
    check(!gnt_valid, "R1 idle", int'(gnt_valid), 0);

    // R5 R10 R1: every occupancy mask, excess only, pointer at group 0
    for (int m = 0; m < 16; m++) begin
      int lo;
      do_reset();
      q_nonempty = 4'(m);
      lo = 0;
      while (lo < 4 && !m[lo]) lo++;
      if (m == 0) begin
        repeat (10) @(negedge clk);
        check(!gnt_valid, "R1 empty mask", int'(gnt_valid), 0);
      end else expect_grant("R5 mask lowest", lo, 0);
    end

    // R3 R4: priority sweeps
    for (int p = 0; p < 4; p++) begin
      do_reset(); q_nonempty = 4'hF; cfg_p1_en = 1'b1; cfg_p1_id = 2'(p);
      expect_grant("R4 p1", p, 3);
      do_reset(); q_nonempty = 4'hF; cfg_p2_en = 1'b1; cfg_p2_id = 2'(p);
      expect_grant("R4 p2", p, 2);
      do_reset(); q_nonempty = 4'hF; cfg_p1_en = 1'b1; cfg_p1_id = 2'(p);
      cfg_p2_en = 1'b1; cfg_p2_id = 2'((p + 1) % 4);
      expect_grant("R3 p1 over p2", p, 3);
    end

    // R2: hold under back-pressure, gap, then fresh decision
    do_reset(); q_nonempty = 4'hF; cfg_p1_en = 1'b1; cfg_p1_id = 2'd1;
    expect_grant("R2 first", 1, 3);
    cfg_p1_id = 2'd2;
    repeat (3) @(negedge clk);
    check(gnt_valid && gnt_idx == 2'd1, "R2 held", int'(gnt_idx), 1);
    ack(10);
    check(!gnt_valid, "R2 gap", int'(gnt_valid), 0);
    expect_grant("R2 next", 2, 3);

    // R9 R5: committed leaf in group 1 beats pointer at group 0
    do_reset(); cfg_min_rate[24 +: 8] = 8'd20; tick(); q_nonempty = 4'hF;
    expect_grant("R9 R5 committed wins", 3, 1);

    // R6: two committed leaves in different groups alternate
    do_reset(); cfg_min_rate = {8'd0, 8'd200, 8'd0, 8'd200};
    cfg_max_rate = {4{8'd200}}; tick(); q_nonempty = 4'b0101;
    for (int k = 0; k < 4; k++) begin
      expect_grant("R6 rotate", (k % 2) * 2, 1);
      ack(10);
    end

    // R10: weights 20:10 give 0,0,1 pattern
    do_reset(); cfg_max_rate = {4{8'd100}}; repeat (3) tick();
    cfg_weight = {8'd16, 8'd16, 8'd10, 8'd20}; q_nonempty = 4'b0011;
    for (int k = 0; k < 6; k++) begin
      expect_grant("R10 drr", (k % 3 == 2) ? 1 : 0, 0);
      ack(10);
    end

    // R7: overdraft silences leaf, one refill restores it
    do_reset(); q_nonempty = 4'b0001;
    expect_grant("R7 before", 0, 0);
    ack(10);
    repeat (10) @(negedge clk);
    check(!gnt_valid, "R7 ineligible", int'(gnt_valid), 0);
    cfg_max_rate[7:0] = 8'd10; tick();
    expect_grant("R7 restored", 0, 0);

    // R8: five refills of 100 saturate at 255 -> three committed grants of 100
    do_reset(); cfg_min_rate[24 +: 8] = 8'd100; cfg_max_rate[24 +: 8] = 8'd100;
    repeat (5) tick();
    cfg_min_rate = '0; q_head_len[24 +: 8] = 8'd100; cfg_weight[24 +: 8] = 8'd200;
    q_nonempty = 4'b1000;
    for (int k = 0; k < 4; k++) begin
      expect_grant("R8 saturation", 3, (k < 3) ? 1 : 0);
      ack(100);
      tick();
    end

    summary();
    $finish;
  end
endmodule